// File: doc/BRIEF.md
# USB Suspend and Resume Status Register

This block is an eight-bit control and status register placed between a USB serial interface engine and a small microcontroller. The engine side reports three conditions: the bus is suspended, a bus reset is in progress, and resume signalling has been detected. The register records these as read-only status flags and raises a single-cycle interrupt request whenever one of them turns on. The microcontroller side is a plain read/write port. Through it the CPU can issue a remote-wakeup command, switch an on-chip regulator on or off, and choose whether a USB bus reset also resets the CPU core.

The resume flag latches when the engine detects resume signalling, and it also produces a wake-up pulse. It clears by itself when the suspend indication drops. The gated CPU reset output is combinational. It stays asserted for as long as the engine reports a bus reset and the reset-enable bit is 1. After a system reset only the reset-enable bit is 1. All edge history is cleared at the same time, so the block starts quiet.

Top module: `usb_susp_ctl`

## Requirements
- R1: While `rst` is high, and on the first read after it falls, `cpu_rdata` equals 8'h80. During reset `usb_irq`, `wake_req`, `rwk_cmd` and `reg_en` are 0.
- R2: Bit 0 of `cpu_rdata` (suspended) shows the value `sie_suspend` had at the previous clock edge.
- R3: When bit 0 turns from 0 to 1, `usb_irq` is 1 for exactly the cycle in which bit 0 first reads 1. When bit 0 turns from 1 to 0, no interrupt is raised.
- R4: Bit 2 (bus reset seen) shows the value `sie_busrst` had at the previous clock edge. When bit 2 turns from 0 to 1, `usb_irq` pulses in the cycle in which it first reads 1.
- R5: A clock edge with `sie_resume_det` high sets bit 3 (resumed). When bit 3 turns from 0 to 1, `usb_irq` and `wake_req` both pulse in the cycle in which it first reads 1.
- R6: Bit 3 clears when bit 0 falls. If a resume detection arrives at the same edge, the clear wins. While bit 0 holds, bit 3 keeps its value.
- R7: A write (`cpu_we` high at a clock edge) loads bits 1, 4 and 7 from `cpu_wdata`. Written values to bits 0, 2, 3, 5 and 6 have no effect on `cpu_rdata`.
- R8: `rwk_cmd` equals bit 1 (remote wakeup) and `reg_en` equals bit 4 (regulator on).
- R9: Bits 5 and 6 of `cpu_rdata` always read 0.
- R10: `cpu_rst` equals `sie_busrst` AND bit 7 (bus reset resets CPU), combinationally.
- R11: A flag held high gives only one interrupt pulse. Flags rising at the same edge give one pulse, not several.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high system reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Register image as read by the CPU |
| sie_suspend | input | 1 | Engine reports bus suspended |
| sie_busrst | input | 1 | Engine reports bus reset in progress |
| sie_resume_det | input | 1 | Engine detected resume signalling |
| usb_irq | output | 1 | One-cycle USB interrupt request |
| wake_req | output | 1 | One-cycle wake-up request on resume |
| rwk_cmd | output | 1 | Remote-wakeup command to the engine |
| reg_en | output | 1 | Regulator output enable |
| cpu_rst | output | 1 | Gated CPU core reset |

## Verification
The flags are driven one at a time and held over several cycles. This shows that a single rise gives one pulse and that a held level gives no further pulses. A falling suspend is driven alone and also together with a new resume detection, which shows that the self-clear takes priority over setting. An all-ones write and then an all-zeros write show which bits the CPU can change. A bus reset is applied with the reset-enable bit at 1 and again at 0, which shows that the CPU reset gating follows that bit. Finally, several flags rise at once to confirm that they merge into one interrupt pulse, and a mid-run reset confirms that the register returns to its reset image.

// File: rtl/usr_pkg.sv
package usr_pkg;

    localparam int REG_W   = 8;
    localparam int NUM_EVT = 3;

    // bit positions in the CPU-visible image
    localparam int B_SUSP   = 0;
    localparam int B_RMWK   = 1;
    localparam int B_BRST   = 2;
    localparam int B_RESUME = 3;
    localparam int B_REGEN  = 4;
    localparam int B_RSTEN  = 7;

    // event vector indices
    localparam int E_SUSP   = 0;
    localparam int E_BRST   = 1;
    localparam int E_RESUME = 2;

    typedef struct packed {
        logic resume;
        logic brst;
        logic susp;
    } evt_t;

    typedef struct packed {
        logic rst_en;
        logic reg_on;
        logic rwk;
    } ctl_t;

    localparam ctl_t CTL_RST = '{rst_en: 1'b1, reg_on: 1'b0, rwk: 1'b0};
    localparam evt_t EVT_RST = '{resume: 1'b0, brst: 1'b0, susp: 1'b0};

    function automatic ctl_t ctl_from_bus(input logic [REG_W-1:0] d);
        ctl_t c;
        c.rst_en = d[B_RSTEN];
        c.reg_on = d[B_REGEN];
        c.rwk    = d[B_RMWK];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_image(input evt_t e, input ctl_t c);
        logic [REG_W-1:0] r;
        r           = '0;
        r[B_SUSP]   = e.susp;
        r[B_RMWK]   = c.rwk;
        r[B_BRST]   = e.brst;
        r[B_RESUME] = e.resume;
        r[B_REGEN]  = c.reg_on;
        r[B_RSTEN]  = c.rst_en;
        return r;
    endfunction

endpackage

// File: rtl/usr_ctl_regs.sv
module usr_ctl_regs
    import usr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output ctl_t             ctl
);
    ctl_t ctl_q;
    ctl_t ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (we) ctl_d = ctl_from_bus(wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= CTL_RST;
        else     ctl_q <= ctl_d;
    end

    assign ctl = ctl_q;
endmodule

// File: rtl/usr_stat_flags.sv
module usr_stat_flags
    import usr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic suspend_in,
    input  logic busrst_in,
    input  logic resume_det_in,
    output evt_t cur,
    output evt_t nxt
);
    evt_t cur_q;
    evt_t nxt_c;
    logic susp_fall;

    assign susp_fall = cur_q.susp & ~suspend_in;

    always_comb begin
        nxt_c.susp = suspend_in;
        nxt_c.brst = busrst_in;
        if (susp_fall)          nxt_c.resume = 1'b0;
        else if (resume_det_in) nxt_c.resume = 1'b1;
        else                    nxt_c.resume = cur_q.resume;
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= EVT_RST;
        else     cur_q <= nxt_c;
    end

    assign cur = cur_q;
    assign nxt = nxt_c;
endmodule

// File: rtl/usr_edge_det.sv
module usr_edge_det #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cur,
    input  logic [N-1:0] nxt,
    output logic [N-1:0] rise
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic pulse_q;
        always_ff @(posedge clk) begin
            if (rst) pulse_q <= 1'b0;
            else     pulse_q <= nxt[i] & ~cur[i];
        end
        assign rise[i] = pulse_q;
    end
endmodule

// File: rtl/usb_susp_ctl.sv
module usb_susp_ctl
    import usr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_we,
    input  logic [REG_W-1:0] cpu_wdata,
    output logic [REG_W-1:0] cpu_rdata,
    input  logic             sie_suspend,
    input  logic             sie_busrst,
    input  logic             sie_resume_det,
    output logic             usb_irq,
    output logic             wake_req,
    output logic             rwk_cmd,
    output logic             reg_en,
    output logic             cpu_rst
);
    ctl_t               ctl;
    evt_t               ev_cur;
    evt_t               ev_nxt;
    logic [NUM_EVT-1:0] rise;

    usr_ctl_regs u_ctl (
        .clk   (clk),
        .rst   (rst),
        .we    (cpu_we),
        .wdata (cpu_wdata),
        .ctl   (ctl)
    );

    usr_stat_flags u_flags (
        .clk           (clk),
        .rst           (rst),
        .suspend_in    (sie_suspend),
        .busrst_in     (sie_busrst),
        .resume_det_in (sie_resume_det),
        .cur           (ev_cur),
        .nxt           (ev_nxt)
    );

    usr_edge_det #(.N(NUM_EVT)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .cur  (ev_cur),
        .nxt  (ev_nxt),
        .rise (rise)
    );

    assign cpu_rdata = pack_image(ev_cur, ctl);
    assign usb_irq   = |rise;
    assign wake_req  = rise[E_RESUME];
    assign rwk_cmd   = ctl.rwk;
    assign reg_en    = ctl.reg_on;
    assign cpu_rst   = sie_busrst & ctl.rst_en;
endmodule

// File: rtl/usb_susp_ctl_chk.sv
module usb_susp_ctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cpu_we,
    input logic [7:0] cpu_wdata,
    input logic [7:0] cpu_rdata,
    input logic       sie_busrst,
    input logic       usb_irq,
    input logic       wake_req,
    input logic       rwk_cmd,
    input logic       reg_en,
    input logic       cpu_rst
);
    AST_RESET_IMAGE: assert property (@(posedge clk) rst |=> (cpu_rdata == 8'h80) && !usb_irq); // R1
    AST_IRQ_HAS_RISE: assert property (@(posedge clk) disable iff (rst)
        usb_irq |-> ((cpu_rdata[0] && !$past(cpu_rdata[0])) || (cpu_rdata[2] && !$past(cpu_rdata[2]))
                     || (cpu_rdata[3] && !$past(cpu_rdata[3])))); // R3
    AST_WAKE_WITH_RESUME: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> cpu_rdata[3] && usb_irq); // R5
    AST_RESUME_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_rdata[0]) |-> !cpu_rdata[3]); // R6
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
        cpu_we |=> (cpu_rdata[7] == $past(cpu_wdata[7])) && (cpu_rdata[4] == $past(cpu_wdata[4]))
                   && (cpu_rdata[1] == $past(cpu_wdata[1]))); // R7
    AST_CTL_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
        (rwk_cmd == cpu_rdata[1]) && (reg_en == cpu_rdata[4])); // R8
    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
        cpu_rdata[6:5] == 2'b00); // R9
    AST_CPU_RST_GATE: assert property (@(posedge clk) disable iff (rst)
        cpu_rst == (sie_busrst && cpu_rdata[7])); // R10
endmodule

bind usb_susp_ctl usb_susp_ctl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_we     (cpu_we),
    .cpu_wdata  (cpu_wdata),
    .cpu_rdata  (cpu_rdata),
    .sie_busrst (sie_busrst),
    .usb_irq    (usb_irq),
    .wake_req   (wake_req),
    .rwk_cmd    (rwk_cmd),
    .reg_en     (reg_en),
    .cpu_rst    (cpu_rst)
);

// File: tb/usb_susp_ctl_bench.sv
module usb_susp_ctl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_we = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       sie_suspend = 1'b0;
    logic       sie_busrst = 1'b0;
    logic       sie_resume_det = 1'b0;
    logic       usb_irq, wake_req, rwk_cmd, reg_en, cpu_rst;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    usb_susp_ctl u_usb_susp_ctl (
        .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .sie_suspend(sie_suspend), .sie_busrst(sie_busrst), .sie_resume_det(sie_resume_det),
        .usb_irq(usb_irq), .wake_req(wake_req), .rwk_cmd(rwk_cmd), .reg_en(reg_en), .cpu_rst(cpu_rst)
    );

    // {we, wdata[8], susp, brst, rdet, exp_rdata[8], exp_irq, exp_wake, exp_crst}
    localparam int NV = 15;
    localparam logic [22:0] VEC [NV] = '{
        {1'b0, 8'h00, 3'b000, 8'h80, 3'b000},  // idle
        {1'b0, 8'h00, 3'b100, 8'h81, 3'b100},  // suspend rises
        {1'b0, 8'h00, 3'b100, 8'h81, 3'b000},  // held, no repeat
        {1'b0, 8'h00, 3'b101, 8'h89, 3'b110},  // resume detected
        {1'b0, 8'h00, 3'b100, 8'h89, 3'b000},  // resume held
        {1'b0, 8'h00, 3'b000, 8'h80, 3'b000},  // suspend falls, resume clears
        {1'b0, 8'h00, 3'b010, 8'h84, 3'b101},  // bus reset rises
        {1'b0, 8'h00, 3'b010, 8'h84, 3'b001},  // bus reset held
        {1'b0, 8'h00, 3'b000, 8'h80, 3'b000},  // bus reset ends
        {1'b1, 8'hFF, 3'b000, 8'h92, 3'b000},  // write all ones
        {1'b1, 8'h00, 3'b000, 8'h00, 3'b000},  // write all zeros
        {1'b0, 8'h00, 3'b010, 8'h04, 3'b100},  // bus reset, gating off
        {1'b1, 8'h80, 3'b100, 8'h81, 3'b100},  // suspend rises with write
        {1'b0, 8'h00, 3'b111, 8'h8D, 3'b111},  // two flags rise together
        {1'b0, 8'h00, 3'b001, 8'h80, 3'b000}   // fall and resume: clear wins
    };

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R1";   1: return "R3";  2: return "R11"; 3: return "R5";
            4: return "R6";   5: return "R6";  6: return "R4";  7: return "R10";
            8: return "R4";   9: return "R7"; 10: return "R8"; 11: return "R10";
            12: return "R2"; 13: return "R11"; default: return "R6";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    initial begin : watchdog
        #1000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] exp_img;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "rdata in reset", cpu_rdata, 8'h80);
        chk("R1", "irq in reset", {7'd0, usb_irq}, 8'h00);
        chk("R1", "outputs in reset", {5'd0, wake_req, rwk_cmd, reg_en}, 8'h00);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            {cpu_we, cpu_wdata, sie_suspend, sie_busrst, sie_resume_det} = VEC[i][22:11];
            @(negedge clk);
            exp_img = VEC[i][10:3];
            chk(vec_tag(i), "rdata", cpu_rdata, exp_img);
            chk(vec_tag(i), "irq", {7'd0, usb_irq}, {7'd0, VEC[i][2]});
            chk(vec_tag(i), "wake", {7'd0, wake_req}, {7'd0, VEC[i][1]});
            chk(vec_tag(i), "cpu_rst", {7'd0, cpu_rst}, {7'd0, VEC[i][0]});
            chk("R8", "rwk/reg_en", {6'd0, rwk_cmd, reg_en}, {6'd0, exp_img[1], exp_img[4]});
            chk("R9", "spare bits", {6'd0, cpu_rdata[6:5]}, 8'h00);
        end

        // R10 combinational: reset-enable on, bus reset raised between edges
        cpu_we = 1'b0; sie_suspend = 1'b0; sie_resume_det = 1'b0; sie_busrst = 1'b0;
        @(negedge clk);
        #2 sie_busrst = 1'b1;
        #1 chk("R10", "cpu_rst same cycle", {7'd0, cpu_rst}, 8'h01);
        sie_busrst = 1'b0;
        @(negedge clk);

        // R7: write with only read-only bits set leaves them clear
        cpu_we = 1'b1; cpu_wdata = 8'h6D;
        @(negedge clk);
        cpu_we = 1'b0;
        chk("R7", "read-only bits ignored", cpu_rdata, 8'h00);

        // R1: mid-run reset restores image
        cpu_we = 1'b1; cpu_wdata = 8'h12;
        @(negedge clk);
        cpu_we = 1'b0; sie_suspend = 1'b1;
        @(negedge clk);
        rst = 1'b1; sie_suspend = 1'b0;
        @(negedge clk);
        chk("R1", "rdata after mid reset", cpu_rdata, 8'h80);
        chk("R1", "ctl outputs after reset", {6'd0, rwk_cmd, reg_en}, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "first read after reset", cpu_rdata, 8'h80);
        chk("R1", "no spurious irq", {7'd0, usb_irq}, 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule